// File: doc/BRIEF.md
# Polarity-Steered Dead-Time Pulse-Width Modulator

This block drives one half-bridge leg. It produces an upper and a lower gate signal from a symmetric triangular carrier. The carrier is a counter that runs up from zero to a programmable period and back down again, moving one step per clock. A signed reference is mapped onto the carrier range, and each gate comes from comparing that level against one of three carriers: the main one, a copy raised by the dead-time, or a copy lowered by the dead-time.

The sign of the load current decides which gate keeps the ideal edges. With positive current the upper gate is compared against the main carrier, so it reproduces the ideal pulse exactly. The lower gate is compared against the lowered carrier and is narrowed on both sides by the dead-time. With negative current the roles swap: the lower gate uses the main carrier and the upper gate uses the raised one. The diode that conducts during the gap then holds the leg voltage where the ideal pulse would put it. As a result, every pulse keeps its volt-seconds without any averaged correction.

The reference, the polarity flag and the dead-time are captured only at the peak and at the valley of the carrier. The carrier period is captured only at the valley. A one-clock sync pulse marks each valley.

Top module: `dtpwm_leg`

## Requirements
- R1: While rst_ni is low, both gates and sync_o are 0. The carrier restarts at count 0 going up, so the first output cycle after release shows sync_o = 1.
- R2: The carrier steps 0,1,…,P,P-1,…,1,0 with P the period captured at the valley. sync_o is high for exactly one cycle per valley, so successive pulses are 2·P clocks apart, and a new period_i takes effect only from the next valley.
- R3: The reference is mapped to the level L = ref_i + floor(P/2) and clamped to the range 0..P.
- R4: With pos_cur_i = 1, the upper gate for carrier count c is high exactly when L > c. This is the unshifted ideal comparator.
- R5: With pos_cur_i = 1, the lower gate is high exactly when L + Td ≤ c, which is the carrier lowered by Td.
- R6: With pos_cur_i = 0, the lower gate is high exactly when L ≤ c (the ideal complement), and the upper gate is high exactly when L > c + Td (the carrier raised by Td).
- R7: The two gates are never high in the same cycle.
- R8: A gate rises only after both gates have been low for at least Td consecutive cycles. This holds even when the captured settings change between pulses.
- R9: Changes to ref_i, pos_cur_i and dead_i take effect only at a carrier peak or valley. Between those points they have no effect on either gate.
- R10: The narrowed gate is held off for the whole pulse when the level is too close to a carrier limit. For positive current this applies when L + 2·Td > P. For negative current it applies when L < 2·Td.
- R11: Each gate output is registered: the value in a cycle reflects the carrier count and captured settings of the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | CNT_W+1 | Signed reference, relative to half the period |
| pos_cur_i | input | 1 | 1 when the load current is positive |
| dead_i | input | TD_W | Dead-time in clocks (carrier counts) |
| period_i | input | CNT_W | Carrier peak count P |
| gate_hi_o | output | 1 | Upper switch gate |
| gate_lo_o | output | 1 | Lower switch gate |
| sync_o | output | 1 | One-cycle pulse at each carrier valley |

## Verification
The assertions assume that the period is at least 2, that twice the dead-time stays below the period, and that the dead-time fits in the TD_W field. Outside these limits the shifted carriers can leave the counting range, and the gap and shadow properties lose their meaning. The stimulus keeps the period at 12, 16 or 20 and the dead-time at 0 to 4, so every setting stays within these limits. It changes the reference, polarity and dead-time both at arbitrary cycles and at carrier turning points. A reference-model carrier in the bench predicts every output cycle.

// File: rtl/dtpwm_pkg.sv
package dtpwm_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;
endpackage

// File: rtl/dtpwm_carrier.sv
module dtpwm_carrier
  import dtpwm_pkg::*;
#(
  parameter int CNT_W      = 10,
  parameter int DEF_PERIOD = 500
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             up_o,
  output logic [CNT_W-1:0] per_o,
  output logic [CNT_W-1:0] per_nxt_o,
  output logic             valley_o,
  output logic             peak_o
);
  localparam logic [CNT_W-1:0] PER_RST = CNT_W'(DEF_PERIOD);

  logic [CNT_W-1:0] cnt_q, per_q;
  dir_e             dir_q;
  logic             valley, peak;

  assign valley    = (cnt_q == '0);
  assign peak      = (dir_q == DIR_UP) && (cnt_q >= per_q) && !valley;
  assign per_nxt_o = valley ? period_i : per_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
      per_q <= PER_RST;
    end else if (valley) begin
      per_q <= period_i;
      cnt_q <= CNT_W'(1);
      dir_q <= DIR_UP;
    end else if (peak) begin
      cnt_q <= cnt_q - CNT_W'(1);
      dir_q <= DIR_DOWN;
    end else if (dir_q == DIR_UP) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end else begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign cnt_o    = cnt_q;
  assign up_o     = (dir_q == DIR_UP);
  assign per_o    = per_q;
  assign valley_o = valley;
  assign peak_o   = peak;
endmodule

// File: rtl/dtpwm_shadow.sv
module dtpwm_shadow #(
  parameter int CNT_W = 10,
  parameter int TD_W  = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [CNT_W-1:0]        per_nxt_i,
  input  logic signed [CNT_W:0]   ref_i,
  input  logic                    pos_i,
  input  logic [TD_W-1:0]         td_i,
  output logic [CNT_W-1:0]        lvl_o,
  output logic [TD_W-1:0]         td_o,
  output logic                    pos_o
);
  localparam int SW = CNT_W + 2;

  logic signed [SW-1:0] sum, half, top;
  logic [CNT_W-1:0]     lvl_d, lvl_q;
  logic [TD_W-1:0]      td_q;
  logic                 pos_q;

  assign half = $signed({2'b00, per_nxt_i >> 1});
  assign top  = $signed({2'b00, per_nxt_i});
  assign sum  = $signed({ref_i[CNT_W], ref_i}) + half;

  // clamp level into the carrier range
  always_comb begin
    if (sum < 0)        lvl_d = '0;
    else if (sum > top) lvl_d = per_nxt_i;
    else                lvl_d = sum[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      td_q  <= '0;
      pos_q <= 1'b1;
    end else if (load_i) begin
      lvl_q <= lvl_d;
      td_q  <= td_i;
      pos_q <= pos_i;
    end
  end

  assign lvl_o = lvl_q;
  assign td_o  = td_q;
  assign pos_o = pos_q;
endmodule

// File: rtl/dtpwm_gate.sv
module dtpwm_gate #(
  parameter int CNT_W = 10,
  parameter int TD_W  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] lvl_i,
  input  logic [TD_W-1:0]  td_i,
  input  logic             pos_i,
  input  logic             valley_i,
  output logic             hi_o,
  output logic             lo_o,
  output logic             sync_o
);
  localparam int            W       = CNT_W + 2;
  localparam logic [TD_W-1:0] GAP_MAX = '1;

  logic [W-1:0] c, l, t, p, t2;
  logic [W-1:0] car_main, car_up, lvl_dn;
  logic         hi_raw, lo_raw, hi_g, lo_g, gap_ok;
  logic         hi_q, lo_q, sync_q;
  logic [TD_W-1:0] gap_q;

  assign c  = {2'b00, cnt_i};
  assign l  = {2'b00, lvl_i};
  assign p  = {2'b00, per_i};
  assign t  = {{(W-TD_W){1'b0}}, td_i};
  assign t2 = t << 1;

  assign car_main = c;
  assign car_up   = c + t;   // raised carrier
  assign lvl_dn   = l + t;   // L + Td <= c  <=>  L <= lowered carrier

  always_comb begin
    if (pos_i) begin
      hi_raw = l > car_main;
      lo_raw = (lvl_dn <= car_main) && !((l + t2) > p);
    end else begin
      lo_raw = l <= car_main;
      hi_raw = (l > car_up) && !(l < t2);
    end
  end

  // a rising edge needs Td low cycles on both gates
  assign gap_ok = (gap_q >= td_i);
  assign hi_g   = hi_raw && (hi_q || gap_ok);
  assign lo_g   = lo_raw && !hi_g && (lo_q || gap_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
      sync_q <= 1'b0;
      gap_q  <= GAP_MAX;
    end else begin
      hi_q   <= hi_g;
      lo_q   <= lo_g;
      sync_q <= valley_i;
      if (hi_g || lo_g)       gap_q <= '0;
      else if (gap_q != GAP_MAX) gap_q <= gap_q + TD_W'(1);
    end
  end

  assign hi_o   = hi_q;
  assign lo_o   = lo_q;
  assign sync_o = sync_q;
endmodule

// File: rtl/dtpwm_leg.sv
module dtpwm_leg #(
  parameter int CNT_W      = 10,
  parameter int TD_W       = 6,
  parameter int DEF_PERIOD = 500
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic signed [CNT_W:0] ref_i,
  input  logic                  pos_cur_i,
  input  logic [TD_W-1:0]       dead_i,
  input  logic [CNT_W-1:0]      period_i,
  output logic                  gate_hi_o,
  output logic                  gate_lo_o,
  output logic                  sync_o
);
  logic [CNT_W-1:0] car_cnt, car_per, car_per_nxt, sh_lvl;
  logic             car_up, car_valley, car_peak, sh_pol;
  logic [TD_W-1:0]  sh_td;

  dtpwm_carrier #(
    .CNT_W     (CNT_W),
    .DEF_PERIOD(DEF_PERIOD)
  ) u_carrier (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .period_i (period_i),
    .cnt_o    (car_cnt),
    .up_o     (car_up),
    .per_o    (car_per),
    .per_nxt_o(car_per_nxt),
    .valley_o (car_valley),
    .peak_o   (car_peak)
  );

  dtpwm_shadow #(
    .CNT_W(CNT_W),
    .TD_W (TD_W)
  ) u_shadow (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (car_valley | car_peak),
    .per_nxt_i(car_per_nxt),
    .ref_i    (ref_i),
    .pos_i    (pos_cur_i),
    .td_i     (dead_i),
    .lvl_o    (sh_lvl),
    .td_o     (sh_td),
    .pos_o    (sh_pol)
  );

  dtpwm_gate #(
    .CNT_W(CNT_W),
    .TD_W (TD_W)
  ) u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cnt_i   (car_cnt),
    .per_i   (car_per),
    .lvl_i   (sh_lvl),
    .td_i    (sh_td),
    .pos_i   (sh_pol),
    .valley_i(car_valley),
    .hi_o    (gate_hi_o),
    .lo_o    (gate_lo_o),
    .sync_o  (sync_o)
  );
endmodule

// File: rtl/dtpwm_leg_chk.sv
module dtpwm_leg_chk #(
  parameter int CNT_W = 10,
  parameter int TD_W  = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hi_i,
  input logic             lo_i,
  input logic             sync_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             up_i,
  input logic [CNT_W-1:0] per_i,
  input logic [CNT_W-1:0] lvl_i,
  input logic [TD_W-1:0]  td_i,
  input logic             pol_i
);
  localparam logic [TD_W-1:0] RUN_MAX = '1;
  logic [TD_W-1:0] low_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            low_run <= RUN_MAX;
    else if (hi_i || lo_i)  low_run <= '0;
    else if (low_run != RUN_MAX) low_run <= low_run + TD_W'(1);
  end

  always @(posedge clk_i) begin
    if (!rst_ni) AST_RESET_IDLE: assert (!hi_i && !lo_i && !sync_i); // R1
  end

  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hi_i && lo_i)); // R7

  AST_GAP_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hi_i) |-> low_run >= $past(td_i)); // R8

  AST_GAP_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lo_i) |-> low_run >= $past(td_i)); // R8

  AST_SYNC_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> !sync_i); // R2

  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i != '0) && !(up_i && (cnt_i >= per_i))
    |=> $stable(lvl_i) && $stable(td_i) && $stable(pol_i)); // R9
endmodule

bind dtpwm_leg dtpwm_leg_chk #(
  .CNT_W(CNT_W),
  .TD_W (TD_W)
) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .hi_i  (gate_hi_o),
  .lo_i  (gate_lo_o),
  .sync_i(sync_o),
  .cnt_i (car_cnt),
  .up_i  (car_up),
  .per_i (car_per),
  .lvl_i (sh_lvl),
  .td_i  (sh_td),
  .pol_i (sh_pol)
);

// File: tb/dtpwm_leg_bench.sv
module dtpwm_leg_bench;
  localparam int CNT_W   = 8;
  localparam int TD_W    = 3;
  localparam int GAP_MAX = (1 << TD_W) - 1;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic signed [CNT_W:0] ref_r = '0;
  logic                  pol_r = 1'b1;
  logic [TD_W-1:0]       dead_r = '0;
  logic [CNT_W-1:0]      period_r = CNT_W'(16);
  logic                  hi, lo, sync;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string phase_tag = "";

  // reference model state
  int m_cnt, m_per, m_lvl, m_td, m_gap;
  bit m_up, m_pol, m_hi, m_lo, m_sync;
  int low_run, last_td, since_sync, per_at_sync;
  bit prev_hi, prev_lo, seen_sync;

  always #10 clk = ~clk;

  dtpwm_leg #(
    .CNT_W     (CNT_W),
    .TD_W      (TD_W),
    .DEF_PERIOD(16)
  ) u_dtpwm_leg (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .ref_i    (ref_r),
    .pos_cur_i(pol_r),
    .dead_i   (dead_r),
    .period_i (period_r),
    .gate_hi_o(hi),
    .gate_lo_o(lo),
    .sync_o   (sync)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_up = 1; m_per = 16; m_lvl = 0; m_td = 0; m_pol = 1;
    m_gap = GAP_MAX; m_hi = 0; m_lo = 0; m_sync = 0;
    low_run = 1000; last_td = 0; prev_hi = 0; prev_lo = 0;
    seen_sync = 0; since_sync = 0; per_at_sync = 0;
  endtask

  task automatic tick();
    bit valley, peak, hr, lr, hg, lg, sup_hi, sup_lo, gap_ok;
    int c, l, t, p, pn, s;
    string th, tl;
    valley = (m_cnt == 0);
    peak   = m_up && (m_cnt >= m_per) && !valley;
    c = m_cnt; l = m_lvl; t = m_td; p = m_per;
    sup_hi = 0; sup_lo = 0;
    if (m_pol) begin
      hr = l > c;
      lr = (l + t <= c) && !(l + 2 * t > p);
      sup_lo = (l + t <= c) && (l + 2 * t > p);
    end else begin
      lr = l <= c;
      hr = (l > c + t) && !(l < 2 * t);
      sup_hi = (l > c + t) && (l < 2 * t);
    end
    gap_ok = m_gap >= t;
    hg = hr && (m_hi || gap_ok);
    lg = lr && !hg && (m_lo || gap_ok);
    m_gap = (hg || lg) ? 0 : ((m_gap >= GAP_MAX) ? GAP_MAX : m_gap + 1);
    m_hi = hg; m_lo = lg; m_sync = valley;
    last_td = t;
    if (valley || peak) begin
      pn = valley ? int'(period_r) : m_per;
      s  = int'(ref_r) + pn / 2;
      m_lvl = (s < 0) ? 0 : ((s > pn) ? pn : s);
      m_td  = int'(dead_r);
      m_pol = pol_r;
    end
    if (valley) begin
      m_per = int'(period_r); m_cnt = 1; m_up = 1;
    end else if (peak) begin
      m_cnt = m_cnt - 1; m_up = 0;
    end else if (m_up) m_cnt = m_cnt + 1;
    else m_cnt = m_cnt - 1;

    @(posedge clk);
    @(negedge clk);

    th = m_pol ? "R4" : "R6";
    tl = m_pol ? "R5" : "R6";
    if (sup_hi) th = "R10";
    if (sup_lo) tl = "R10";
    if (phase_tag != "") begin th = phase_tag; tl = phase_tag; end
    chk(hi == m_hi, th, "gate_hi (R11 timing)", int'(hi), int'(m_hi));
    chk(lo == m_lo, tl, "gate_lo (R11 timing)", int'(lo), int'(m_lo));
    chk(sync == m_sync, "R2", "sync", int'(sync), int'(m_sync));
    chk(!(hi && lo), "R7", "overlap", int'(hi && lo), 0);
    if ((hi && !prev_hi) || (lo && !prev_lo))
      chk(low_run >= last_td, "R8", "dead gap", low_run, last_td);
    low_run = (hi || lo) ? 0 : low_run + 1;
    prev_hi = hi; prev_lo = lo;
    since_sync++;
    if (sync) begin
      if (seen_sync) chk(since_sync == 2 * per_at_sync, "R2", "sync spacing", since_sync, 2 * per_at_sync);
      seen_sync = 1; since_sync = 0; per_at_sync = m_per;
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    chk(!hi && !lo && !sync, "R1", "outputs in reset", int'({hi, lo, sync}), 0);
    rst_n = 1'b1;
    tick();
    chk(sync == 1'b1, "R1", "first valley sync", int'(sync), 1);
    run(40);

    // polarity x dead-time x reference sweep
    for (int pol = 0; pol < 2; pol++)
      for (int td = 0; td <= 4; td++)
        for (int rf = -10; rf <= 10; rf++) begin
          pol_r = pol[0]; dead_r = TD_W'(td); ref_r = (CNT_W+1)'(rf);
          run(64);
        end

    // mid-pulse updates must wait for a turning point
    phase_tag = "R9";
    for (int k = 0; k < 60; k++) begin
      ref_r  = (CNT_W+1)'(int'($urandom_range(20)) - 10);
      pol_r  = 1'($urandom_range(1));
      dead_r = TD_W'($urandom_range(4));
      run(7 + (k % 5));
    end

    // clamping of the level
    phase_tag = "R3";
    dead_r = TD_W'(2);
    for (int pol = 0; pol < 2; pol++) begin
      pol_r = pol[0];
      ref_r = (CNT_W+1)'(200);  run(70);
      ref_r = (CNT_W+1)'(-200); run(70);
    end

    // period capture at valley
    phase_tag = "R2";
    ref_r = (CNT_W+1)'(3); pol_r = 1'b1; dead_r = TD_W'(1);
    run(13);
    period_r = CNT_W'(12); run(90);
    period_r = CNT_W'(20); run(5);
    pol_r = 1'b0; run(120);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL R2 watchdog act=%0d exp=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule